// File: doc/BRIEF.md
# Micro-op Interrupt Restart Point Tracker

In a core that cracks each instruction into as many as eight micro-ops, an asynchronous interrupt can land between two micro-ops of the same instruction. This block records where the interrupt landed and works out where execution resumes. The restart point is a fixed-point program counter: the integer part is the instruction address, and three fractional bits give the position of the interrupted micro-op inside its instruction. When the interrupt is accepted, the block captures that value, together with the reorder-buffer slot of the interrupted micro-op.

A policy input is sampled together with the accept strobe. The exact policy restarts at the interrupted micro-op itself. The round-down policy clears the fractional bits, so the whole instruction runs again from its first micro-op. In both cases the block also reports the reorder-buffer slot that holds the instruction's first micro-op. It finds that slot by subtracting the micro-op position from the interrupted slot, modulo the buffer depth, so no search of the buffer is needed.

Top module: `uop_restart_tracker`

## Requirements
- R1: While reset is high, and at the first sample after it is released, `rp_valid` is 0 and `restart_pc`, `lead_slot` and `resume_slot` are all 0.
- R2: `rp_valid` becomes 1 one cycle after a cycle with `irq_take` high, and stays 1 until reset.
- R3: When `irq_take` is high with `round_down` = 0 (exact policy), `restart_pc` one cycle later equals `{irq_pc, irq_uop}`: the instruction address sits above a 3-bit fractional field that holds the micro-op position.
- R4: When `irq_take` is high with `round_down` = 1, `restart_pc` one cycle later equals `{irq_pc, 3'b000}`.
- R5: One cycle after `irq_take`, `lead_slot` equals `(irq_slot - irq_uop) mod ROB_DEPTH`. The subtraction wraps below slot 0.
- R6: One cycle after `irq_take`, `resume_slot` equals `irq_slot` under the exact policy and equals the R5 lead slot under round-down.
- R7: In cycles with `irq_take` low, all outputs keep their values, whatever `irq_pc`, `irq_uop`, `irq_slot` or `round_down` do.
- R8: A later `irq_take` replaces every captured value with the values computed from the new inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_take | input | 1 | Interrupt accepted against the micro-op presented this cycle |
| irq_pc | input | PC_W | Instruction address of the interrupted micro-op |
| irq_uop | input | 3 | Position of the interrupted micro-op inside its instruction |
| irq_slot | input | $clog2(ROB_DEPTH) | Reorder-buffer slot of the interrupted micro-op |
| round_down | input | 1 | Restart policy: 0 exact, 1 round down to the instruction start |
| rp_valid | output | 1 | A restart point has been captured |
| restart_pc | output | PC_W+3 | Fixed-point restart address |
| lead_slot | output | $clog2(ROB_DEPTH) | Slot of the instruction's first micro-op |
| resume_slot | output | $clog2(ROB_DEPTH) | Slot where execution resumes under the chosen policy |

## Verification
Every result is registered once, so all four outputs are due exactly one clock edge after the cycle in which `irq_take` is high. The bench drives the inputs on the falling edge, holds the strobe for one cycle, and samples on the next falling edge, after that single register stage has updated. The sweep covers all eight micro-op positions, all slots of a 16-entry buffer and both policies, so every wrap-around case is reached. Between captures the bench scrambles the inputs while the strobe is low and samples one cycle later to confirm that the outputs hold.

// File: rtl/upr_pkg.sv
package upr_pkg;
  // Width of the fractional micro-op field of the restart PC.
  localparam int UOP_W     = 3;
  localparam int UOP_SLOTS = 1 << UOP_W;
  // Policy encodings on the round_down input.
  localparam logic POLICY_EXACT = 1'b0;
  localparam logic POLICY_ROUND = 1'b1;
endpackage

// File: rtl/upr_lead_calc.sv
module upr_lead_calc #(
  parameter int ROB_DEPTH = 16,
  localparam int IDX_W = $clog2(ROB_DEPTH)
) (
  input  logic [IDX_W-1:0]          slot_in,
  input  logic [upr_pkg::UOP_W-1:0] uop_in,
  output logic [IDX_W-1:0]          lead_out
);
  // Depth is a power of two, so the modulo is a truncation of a wide difference.
  localparam int SUM_W = IDX_W + upr_pkg::UOP_W;
  logic [SUM_W-1:0] diff;

  always_comb begin
    diff     = SUM_W'(slot_in) - SUM_W'(uop_in);
    lead_out = diff[IDX_W-1:0];
  end
endmodule

// File: rtl/upr_policy_sel.sv
module upr_policy_sel #(
  parameter int PC_W = 32,
  parameter int ROB_DEPTH = 16,
  localparam int IDX_W = $clog2(ROB_DEPTH),
  localparam int FPC_W = PC_W + upr_pkg::UOP_W
) (
  input  logic [PC_W-1:0]           pc_in,
  input  logic [upr_pkg::UOP_W-1:0] uop_in,
  input  logic [IDX_W-1:0]          slot_in,
  input  logic [IDX_W-1:0]          lead_in,
  input  logic                      policy_in,
  output logic [FPC_W-1:0]          fpc_out,
  output logic [IDX_W-1:0]          resume_out
);
  always_comb begin
    if (policy_in == upr_pkg::POLICY_ROUND) begin
      fpc_out    = {pc_in, {upr_pkg::UOP_W{1'b0}}};
      resume_out = lead_in;
    end else begin
      fpc_out    = {pc_in, uop_in};
      resume_out = slot_in;
    end
  end
endmodule

// File: rtl/upr_capture.sv
module upr_capture #(
  parameter int FPC_W = 35,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [FPC_W-1:0] fpc_d,
  input  logic [IDX_W-1:0] lead_d,
  input  logic [IDX_W-1:0] resume_d,
  output logic             valid_q,
  output logic [FPC_W-1:0] fpc_q,
  output logic [IDX_W-1:0] lead_q,
  output logic [IDX_W-1:0] resume_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= 1'b0;
      fpc_q    <= '0;
      lead_q   <= '0;
      resume_q <= '0;
    end else if (load) begin
      valid_q  <= 1'b1;
      fpc_q    <= fpc_d;
      lead_q   <= lead_d;
      resume_q <= resume_d;
    end
  end
endmodule

// File: rtl/uop_restart_tracker.sv
module uop_restart_tracker #(
  parameter int PC_W = 32,
  parameter int ROB_DEPTH = 16,
  localparam int IDX_W = $clog2(ROB_DEPTH),
  localparam int FPC_W = PC_W + upr_pkg::UOP_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      irq_take,
  input  logic [PC_W-1:0]           irq_pc,
  input  logic [upr_pkg::UOP_W-1:0] irq_uop,
  input  logic [IDX_W-1:0]          irq_slot,
  input  logic                      round_down,
  output logic                      rp_valid,
  output logic [FPC_W-1:0]          restart_pc,
  output logic [IDX_W-1:0]          lead_slot,
  output logic [IDX_W-1:0]          resume_slot
);
  logic [IDX_W-1:0] lead_c;
  logic [IDX_W-1:0] resume_c;
  logic [FPC_W-1:0] fpc_c;

  upr_lead_calc #(.ROB_DEPTH(ROB_DEPTH)) lead_i (
    .slot_in(irq_slot), .uop_in(irq_uop), .lead_out(lead_c)
  );

  upr_policy_sel #(.PC_W(PC_W), .ROB_DEPTH(ROB_DEPTH)) sel_i (
    .pc_in(irq_pc), .uop_in(irq_uop), .slot_in(irq_slot), .lead_in(lead_c),
    .policy_in(round_down), .fpc_out(fpc_c), .resume_out(resume_c)
  );

  upr_capture #(.FPC_W(FPC_W), .IDX_W(IDX_W)) cap_i (
    .clk(clk), .rst(rst), .load(irq_take),
    .fpc_d(fpc_c), .lead_d(lead_c), .resume_d(resume_c),
    .valid_q(rp_valid), .fpc_q(restart_pc), .lead_q(lead_slot), .resume_q(resume_slot)
  );

  // Arms the checks once one clean cycle out of reset has passed.
  logic chk_armed;
  always_ff @(posedge clk) begin
    if (rst) chk_armed <= 1'b0;
    else     chk_armed <= 1'b1;
  end

  p_valid_sets_r2: assert property (@(posedge clk) disable iff (rst)
    irq_take |=> rp_valid);

  p_exact_frac_r3: assert property (@(posedge clk) disable iff (rst)
    (irq_take && !round_down) |=> restart_pc[upr_pkg::UOP_W-1:0] == $past(irq_uop)
                                  && restart_pc[FPC_W-1:upr_pkg::UOP_W] == $past(irq_pc));

  p_round_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (irq_take && round_down) |=> restart_pc[upr_pkg::UOP_W-1:0] == '0);

  p_lead_sum_r5: assert property (@(posedge clk) disable iff (rst)
    irq_take |=> IDX_W'(lead_slot + IDX_W'($past(irq_uop))) == $past(irq_slot));

  p_resume_pick_r6: assert property (@(posedge clk) disable iff (rst)
    (irq_take && round_down) |=> resume_slot == lead_slot);

  p_hold_r7: assert property (@(posedge clk) disable iff (rst || !chk_armed)
    !irq_take |=> $stable(restart_pc) && $stable(lead_slot)
                  && $stable(resume_slot) && $stable(rp_valid));
endmodule

// File: tb/uop_restart_tracker_tb_top.sv
module uop_restart_tracker_tb_top;
  localparam int PC_W = 32;
  localparam int DEPTH = 16;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int FPC_W = PC_W + 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic irq_take = 1'b0;
  logic [PC_W-1:0] irq_pc = '0;
  logic [2:0] irq_uop = '0;
  logic [IDX_W-1:0] irq_slot = '0;
  logic round_down = 1'b0;
  logic rp_valid;
  logic [FPC_W-1:0] restart_pc;
  logic [IDX_W-1:0] lead_slot, resume_slot;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  uop_restart_tracker #(.PC_W(PC_W), .ROB_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .irq_take(irq_take), .irq_pc(irq_pc), .irq_uop(irq_uop),
    .irq_slot(irq_slot), .round_down(round_down), .rp_valid(rp_valid),
    .restart_pc(restart_pc), .lead_slot(lead_slot), .resume_slot(resume_slot)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [FPC_W-1:0] e_pc;
  logic [IDX_W-1:0] e_lead, e_resume;

  task automatic capture(input logic [PC_W-1:0] pc, input int uop, input int slot, input logic rd);
    irq_take = 1'b1; irq_pc = pc; irq_uop = 3'(uop); irq_slot = IDX_W'(slot); round_down = rd;
    e_lead   = IDX_W'((slot + DEPTH - uop) % DEPTH);
    e_pc     = rd ? {pc, 3'b000} : {pc, 3'(uop)};
    e_resume = rd ? e_lead : IDX_W'(slot);
    @(negedge clk);
    irq_take = 1'b0;
    chk("R2", longint'(rp_valid), 1);
    if (rd) chk("R4", longint'(restart_pc), longint'(e_pc));
    else    chk("R3", longint'(restart_pc), longint'(e_pc));
    chk("R5", longint'(lead_slot), longint'(e_lead));
    chk("R6", longint'(resume_slot), longint'(e_resume));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    chk("R1", longint'(rp_valid), 0);
    chk("R1", longint'(restart_pc), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", longint'(rp_valid), 0);
    chk("R1", longint'(restart_pc), 0);
    chk("R1", longint'(lead_slot), 0);
    chk("R1", longint'(resume_slot), 0);

    for (int m = 0; m < 2; m++) begin
      for (int u = 0; u < 8; u++) begin
        for (int s = 0; s < DEPTH; s++) begin
          // R8: each capture overwrites the previous one.
          capture(32'h1000_0000 + 32'(m * 4096 + u * 257 + s * 16), u, s, m[0]);
          if ((s % 5) == 0) begin
            // R7: scramble inputs with the strobe low; outputs must hold.
            irq_pc = ~irq_pc; irq_uop = ~irq_uop; irq_slot = ~irq_slot; round_down = ~round_down;
            @(negedge clk);
            chk("R7", longint'(restart_pc), longint'(e_pc));
            chk("R7", longint'(lead_slot), longint'(e_lead));
            chk("R7", longint'(resume_slot), longint'(e_resume));
            chk("R7", longint'(rp_valid), 1);
          end
        end
      end
    end

    // R8: back-to-back captures, the second one wins.
    irq_take = 1'b1; irq_pc = 32'hAAAA_0000; irq_uop = 3'd7; irq_slot = 4'd2; round_down = 1'b0;
    @(negedge clk);
    capture(32'h5555_1234, 5, 1, 1'b1);
    chk("R8", longint'(lead_slot), 12);
    chk("R8", longint'(restart_pc), longint'({32'h5555_1234, 3'b000}));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule